// File: doc/BRIEF.md
# Framed Two-Byte Serial Word Writer

This block sends 16-bit control words from a host to a serially programmed peripheral. A word is accepted on a valid/ready handshake. It then goes out as two 8-bit transfers, the high byte first, inside a single frame-sync window. The receiving device latches data on the falling edge of the serial clock. The serial clock idles high outside each transfer, and it also stays high through a gap between the two bytes.

The bit period comes from a runtime half-period setting, counted in system clocks. The frame strobe pin is active low by default. A static input turns it into an active-high strobe. A build parameter selects the internal shift direction. An engine that shifts LSB first gets its bits reversed on load, so the wire always carries the word MSB first. Both variants put the same waveform on the wire.

Top module: `frame_serial_writer`

## Requirements
- R1: `in_ready` is high only when no frame is in progress. After a word is accepted, `in_ready` stays low until the frame strobe has been released and a further 2*(`half_period`+1) system clocks have passed.
- R2: The frame strobe asserts at least one bit period before the first falling `sclk` edge. It stays asserted through all 16 falling edges and releases only after the 16th.
- R3: Each frame holds exactly 16 falling `sclk` edges, 8 per byte.
- R4: Falling-edge samples of `sdata`, taken in order, reproduce the accepted word with bit 15 first and bit 0 last.
- R5: `sdata` changes only together with a rising `sclk` edge or while `sclk` is high. It is stable across every falling edge.
- R6: `sclk` is high whenever the strobe is released. Between the 8th and 9th falling edges, `sclk` stays high for at least 2*(`half_period`+1) system clocks.
- R7: The LSB_ENGINE=1 build drives `sclk`, `sdata`, `fsync` and `in_ready` identically to the default build for the same inputs.
- R8: With `fs_active_high`=0 the `fsync` pin is low while a frame is active. With `fs_active_high`=1 it is high while a frame is active. When idle, the pin sits at the opposite level.
- R9: Every low phase of `sclk` lasts exactly `half_period`+1 system clocks.
- R10: After reset, `sclk` is high, `fsync` is inactive and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | DIV_W | Half bit period minus one, in system clocks |
| fs_active_high | input | 1 | 1 selects an active-high frame strobe |
| in_valid | input | 1 | Word offered |
| in_word | input | 16 | Word to send |
| in_ready | output | 1 | Block can accept a word |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, MSB first |
| fsync | output | 1 | Frame strobe |

## Verification
The bench goes after the join between the two bytes. A design that loses the idle gap, or that lets the strobe drop after the first byte, shows up as a short high run at the 9th falling edge or as a frame with only 8 edges. Words with all ones, all zeros and alternating bits are sent under both shift variants. A reversed or byte-swapped load then produces a wrong captured word, and the two instances differ on the wire. Back-to-back offers with several divider settings expose a ready signal that returns before the post-frame strobe-high time, and a low phase that is one clock off.

// File: rtl/frame_serial_writer.sv
module frame_serial_writer #(
  parameter int DIV_W      = 8,
  parameter int BYTE_W     = 8,
  parameter int NBYTES     = 2,
  parameter bit LSB_ENGINE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DIV_W-1:0]         half_period,
  input  logic                     fs_active_high,
  input  logic                     in_valid,
  input  logic [NBYTES*BYTE_W-1:0] in_word,
  output logic                     in_ready,
  output logic                     sclk,
  output logic                     sdata,
  output logic                     fsync
);
  localparam int WORD_W = NBYTES * BYTE_W;
  localparam int BIT_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(NBYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_GAP, S_TAIL, S_HOLD} st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic             tk, hp, frm, sclk_q;
  logic [BIT_W-1:0] bitn;
  logic [IDX_W-1:0] byten;
  logic [WORD_W-1:0] sh, load_w, shift_nxt;
  logic             bit_out;

  wire tick = (cnt == '0);

  generate
    if (LSB_ENGINE) begin : g_lsb
      for (genvar i = 0; i < WORD_W; i++) begin : g_rev
        assign load_w[i] = in_word[WORD_W-1-i];
      end
      assign shift_nxt = {1'b0, sh[WORD_W-1:1]};
      assign bit_out   = sh[0];
    end else begin : g_msb
      assign load_w    = in_word;
      assign shift_nxt = {sh[WORD_W-2:0], 1'b0};
      assign bit_out   = sh[WORD_W-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      tk     <= 1'b0;
      hp     <= 1'b0;
      frm    <= 1'b0;
      sclk_q <= 1'b1;
      bitn   <= '0;
      byten  <= '0;
      sh     <= '0;
    end else begin
      if (st == S_IDLE || tick) cnt <= half_period;
      else                      cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (in_valid) begin
          sh    <= load_w;
          frm   <= 1'b1;
          tk    <= 1'b0;
          hp    <= 1'b0;
          bitn  <= '0;
          byten <= '0;
          st    <= S_LEAD;
        end
        S_LEAD, S_GAP: if (tick) begin
          tk <= ~tk;
          if (tk) st <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!hp) begin
            sclk_q <= 1'b0;
            hp     <= 1'b1;
          end else begin
            sclk_q <= 1'b1;
            hp     <= 1'b0;
            sh     <= shift_nxt;
            bitn   <= bitn + 1'b1;
            if (bitn == LAST_BIT) begin
              bitn <= '0;
              tk   <= 1'b0;
              if (byten == LAST_BYTE) st <= S_TAIL;
              else begin
                byten <= byten + 1'b1;
                st    <= S_GAP;
              end
            end
          end
        end
        S_TAIL: if (tick) begin
          frm <= 1'b0;
          tk  <= 1'b0;
          st  <= S_HOLD;
        end
        S_HOLD: if (tick) begin
          tk <= ~tk;
          if (tk) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready = (st == S_IDLE);
  assign sclk     = sclk_q;
  assign sdata    = bit_out;
  assign fsync    = fs_active_high ? frm : ~frm;

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && frm));
  p_fall_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> frm);
  p_data_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_SHIFT && !$stable(sdata)) |-> $rose(sclk));
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frm |-> sclk);
  p_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (fsync == ~fs_active_high));
endmodule

// File: tb/sim_frame_serial_writer.sv
module sim_frame_serial_writer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] hpc = 8'd0;
  logic pol = 1'b0, in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic rdy0, sclk0, sdata0, fs0, rdy1, sclk1, sdata1, fs1;

  always #2 clk = ~clk;

  frame_serial_writer u0 (.clk(clk), .rst_n(rst_n), .half_period(hpc), .fs_active_high(pol),
    .in_valid(in_valid), .in_word(in_word), .in_ready(rdy0), .sclk(sclk0), .sdata(sdata0), .fsync(fs0));
  frame_serial_writer #(.LSB_ENGINE(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .half_period(hpc),
    .fs_active_high(pol), .in_valid(in_valid), .in_word(in_word), .in_ready(rdy1), .sclk(sclk1),
    .sdata(sdata1), .fsync(fs1));

  int nchk = 0, nbad = 0;
  logic [15:0] q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!rdy0) @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    q.push_back(w);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || !rdy0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: falling-edge receiver and timing scoreboard
  logic prev_sclk = 1'b1, prev_sdata = 1'b0, prev_act = 1'b0;
  logic [15:0] cap = '0;
  int nfall = 0, lowrun = 0, highrun = 0, rwait = 0;
  bit bad_stab = 0, bad_low = 0, diff = 0, idle_bad = 0, waiting = 0;

  always @(negedge clk) if (rst_n) begin
    logic act;
    act = pol ? fs0 : !fs0;
    if ({sclk0, sdata0, fs0, rdy0} !== {sclk1, sdata1, fs1, rdy1}) diff = 1;
    if (!act && sclk0 !== 1'b1) idle_bad = 1;
    if (act && !prev_act) begin
      nfall = 0; cap = '0; bad_stab = 0; bad_low = 0;
    end
    if (!sclk0) lowrun = prev_sclk ? 1 : lowrun + 1;
    else begin
      if (!prev_sclk && lowrun != hpc + 1) bad_low = 1;
      highrun = prev_sclk ? highrun + 1 : 1;
    end
    if (act && prev_sclk && !sclk0) begin
      if (sdata0 !== prev_sdata) bad_stab = 1;
      cap = {cap[14:0], prev_sdata};
      nfall++;
      if (nfall == 9)
        check(highrun >= 2 * (hpc + 1), "R6 gap between bytes", highrun, 2 * (hpc + 1));
    end
    if (waiting) begin
      rwait++;
      if (rdy0) begin
        check(rwait == 2 * (hpc + 1), "R1 ready after strobe high time", rwait, 2 * (hpc + 1));
        waiting = 0;
      end
    end
    if (prev_act && !act) begin
      logic [15:0] exp;
      exp = (q.size() != 0) ? q.pop_front() : 16'hxxxx;
      check(cap === exp, "R4 captured word", cap, exp);
      check(nfall == 16, "R2 R3 falls inside strobe", nfall, 16);
      check(!bad_stab, "R5 sdata stable at falls", bad_stab, 0);
      check(!bad_low, "R9 low phase length", bad_low, 0);
      check(!diff, "R7 lsb engine wire identical", diff, 0);
      check(!idle_bad, "R6 sclk high outside frame", idle_bad, 0);
      check(!rdy0, "R1 ready low at release", rdy0, 0);
      rwait = 0; waiting = 1;
    end
    prev_sclk = sclk0; prev_sdata = sdata0; prev_act = act;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk0 === 1'b1, "R10 sclk idle", sclk0, 1);
    check(fs0 === 1'b1, "R10 fsync inactive", fs0, 1);
    check(rdy0 === 1'b1, "R10 ready", rdy0, 1);
    send(16'hA55A); send(16'h0000); send(16'hFFFF);
    drain();
    hpc = 8'd1;
    send(16'h8001); send(16'h1234);
    drain();
    pol = 1'b1; hpc = 8'd3;
    @(negedge clk);
    check(fs0 === 1'b0, "R8 active-high idle level", fs0, 0);
    send(16'h0F0F); send(16'hC3A5);
    drain();
    pol = 1'b0; hpc = 8'd0;
    @(negedge clk);
    check(fs0 === 1'b1, "R8 active-low idle level", fs0, 1);
    send(16'h7FFE);
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule